// File: doc/BRIEF.md
# USB Endpoint and Core Interrupt Aggregator

This block sits next to a USB OTG controller core. It gathers the core's per-endpoint transmit and receive event lines and its core event lines into two 32-bit source registers, the endpoint bank and the core bank. Each bank has a mask register and a read-only view of the source ANDed with the mask. Software can force source bits high and clear them through write-one aliases. The mask has its own aliases of the same kind.

The block drives a single level interrupt line. The line rises when any masked bit in either bank is pending and the end-of-interrupt gate is armed. Taking the interrupt disarms the gate. Software clears the sources it has serviced and then writes the end-of-interrupt register, which re-arms the gate. If work is still pending after that write, the line asserts again. A control register carries a soft-reset bit, a fixed revision word identifies the block, and a status word shows the line and the gate state.

Top module: `usb_irq_aggregator`

## Requirements
- R1: Byte offsets are as follows. Revision 0x00 reads the fixed nonzero value of parameter REV_VALUE (default 0x0001_0A03). Control is at 0x04 and status at 0x08. The endpoint bank occupies 0x20 to 0x38 in the order source, set, clear, mask, mask-set, mask-clear, masked. The core bank uses the same order at 0x40 to 0x58. End-of-interrupt is at 0x60. Control, the set and clear aliases, end-of-interrupt and unmapped offsets all read as zero.
- R2: In the endpoint bank, `tx_evt[i]` (endpoint i, 0 to 15) maps to bit i and `rx_evt[j-1]` (endpoint j, 1 to 15) maps to bit 16+j. Bit 16 always reads 0, including after a set-alias write of all ones.
- R3: In the core bank, `core_evt[k]` (k = 0 to 8) maps to bit 16+k, so the VBUS-drive event `core_evt[8]` is bit 24. All other bits always read 0.
- R4: A rising edge on an event input sets its source bit at the next clock edge. An input held high does not set the bit again after software clears it.
- R5: Writing ones to a set alias sets the matching valid source bits at that clock edge. Zero bits leave the source unchanged.
- R6: Writing ones to a clear alias clears the matching source bits. If a hardware rising edge hits the same bit in the same cycle, the bit ends up set.
- R7: The mask-set and mask-clear aliases set and clear mask bits. Direct writes to a source or mask offset have no effect.
- R8: The masked register reads as source AND mask for its bank.
- R9: When the gate is armed, `irq` rises one clock after a masked bit becomes pending. It stays high while any masked bit is pending.
- R10: Once `irq` has risen, the gate is disarmed. After the pending bits are cleared, `irq` falls, and new pending bits do not raise it until an end-of-interrupt write.
- R11: A write of any value to end-of-interrupt drives `irq` low at that clock edge and re-arms the gate. If masked bits are still pending, `irq` rises again one clock later.
- R12: Writing control with bit 0 set clears both source and mask registers in both banks, drops `irq` and re-arms the gate. Writing control with bit 0 clear has no effect.
- R13: Status reads bit 0 = `irq` and bit 1 = gate armed. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte address for register write and read |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tx_evt | input | 16 | Transmit event lines, endpoints 0 to 15 |
| rx_evt | input | 15 | Receive event lines, endpoints 1 to 15 |
| core_evt | input | 9 | Core event lines; bit 8 is VBUS drive |
| irq | output | 1 | Level interrupt request |

## Verification
The embedded assertions check the following on every cycle:
- a set-alias write leaves its bits high;
- a hardware rising edge survives a same-cycle clear;
- bits outside each bank's valid field stay zero;
- soft reset empties both banks;
- an end-of-interrupt write drops the line for a cycle;
- the line rises only from an armed gate.

Other behaviours need stimulus over several writes, so only the bench scenarios can show them:
- the endpoint and core bit packing;
- that a held event does not re-set a cleared bit;
- the disarmed gate ignoring new work until end-of-interrupt;
- re-assertion after end-of-interrupt while work remains;
- zero reads from aliases.

// File: rtl/usb_irq_agg_pkg.sv
package usb_irq_agg_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 8;

    // byte offsets of the register window
    localparam logic [ADDR_W-1:0] OFS_REV       = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL      = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT      = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_EP_BASE   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_CORE_BASE = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_EOI       = 8'h60;

    // offsets inside a bank, relative to its base
    localparam logic [ADDR_W-1:0] BK_SRC   = 8'h00;
    localparam logic [ADDR_W-1:0] BK_SET   = 8'h04;
    localparam logic [ADDR_W-1:0] BK_CLR   = 8'h08;
    localparam logic [ADDR_W-1:0] BK_MSK   = 8'h0C;
    localparam logic [ADDR_W-1:0] BK_MSET  = 8'h10;
    localparam logic [ADDR_W-1:0] BK_MCLR  = 8'h14;
    localparam logic [ADDR_W-1:0] BK_MSKD  = 8'h18;

    // software-side strobes delivered to one bank
    typedef struct packed {
        logic [DATA_W-1:0] src_set;
        logic [DATA_W-1:0] src_clr;
        logic [DATA_W-1:0] msk_set;
        logic [DATA_W-1:0] msk_clr;
    } bank_cmd_t;

endpackage

// File: rtl/irq_event_packer.sv
module irq_event_packer
    import usb_irq_agg_pkg::*;
#(
    parameter int unsigned NUM_TX   = 16,
    parameter int unsigned NUM_RX   = 15,
    parameter int unsigned NUM_CORE = 9,
    parameter int unsigned RX_LSB   = 17,
    parameter int unsigned CORE_LSB = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TX-1:0]   tx_evt,
    input  logic [NUM_RX-1:0]   rx_evt,
    input  logic [NUM_CORE-1:0] core_evt,
    output logic [DATA_W-1:0]   ep_rise,
    output logic [DATA_W-1:0]   core_rise
);
    localparam int unsigned ALL_W = NUM_TX + NUM_RX + NUM_CORE;

    logic [ALL_W-1:0] lvl_d, lvl_q;
    logic [ALL_W-1:0] edge_all;

    always_comb begin
        lvl_d    = {core_evt, rx_evt, tx_evt};
        edge_all = lvl_d & ~lvl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    // place each edge at its fixed bit in its bank
    always_comb begin
        ep_rise   = '0;
        core_rise = '0;
        for (int i = 0; i < int'(NUM_TX); i++)
            ep_rise[i] = edge_all[i];
        for (int j = 0; j < int'(NUM_RX); j++)
            ep_rise[RX_LSB + j] = edge_all[NUM_TX + j];
        for (int k = 0; k < int'(NUM_CORE); k++)
            core_rise[CORE_LSB + k] = edge_all[NUM_TX + NUM_RX + k];
    end

endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import usb_irq_agg_pkg::*;
#(
    parameter logic [DATA_W-1:0] VALID = 32'hFFFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [DATA_W-1:0] hw_rise,
    input  bank_cmd_t         cmd,
    output logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] msk,
    output logic [DATA_W-1:0] masked
);
    typedef struct packed {
        logic [DATA_W-1:0] src;
        logic [DATA_W-1:0] msk;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (soft_rst) begin
            st_d = '0;
        end else begin
            // hardware edges and software set both win over clear
            st_d.src = ((st_q.src & ~cmd.src_clr) | cmd.src_set | hw_rise) & VALID;
            st_d.msk = ((st_q.msk & ~cmd.msk_clr) | cmd.msk_set) & VALID;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign src    = st_q.src;
    assign msk    = st_q.msk;
    assign masked = st_q.src & st_q.msk;

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(cmd.src_set & VALID) && !soft_rst) |=>
        ((st_q.src & $past(cmd.src_set & VALID)) == $past(cmd.src_set & VALID))); // R5

    AST_RISE_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hw_rise & cmd.src_clr & VALID) && !soft_rst) |=>
        ((st_q.src & $past(hw_rise & cmd.src_clr & VALID)) == $past(hw_rise & cmd.src_clr & VALID))); // R6

    AST_NO_STRAY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.src & ~VALID) == '0) && ((st_q.msk & ~VALID) == '0)); // R2

    AST_SOFT_RST_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (st_q.src == '0) && (st_q.msk == '0)); // R12

endmodule

// File: rtl/irq_eoi_gate.sv
module irq_eoi_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic eoi_wr,
    input  logic pending,
    output logic irq,
    output logic armed
);
    typedef struct packed {
        logic irq;
        logic armed;
    } gate_state_t;

    gate_state_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (soft_rst || eoi_wr) begin
            g_d.irq   = 1'b0;
            g_d.armed = 1'b1;
        end else begin
            g_d.irq   = pending & (g_q.irq | g_q.armed);
            g_d.armed = g_q.armed & ~pending;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '{irq: 1'b0, armed: 1'b1};
        else        g_q <= g_d;
    end

    assign irq   = g_q.irq;
    assign armed = g_q.armed;

    AST_EOI_DROPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_wr |=> !g_q.irq); // R11

    AST_RISE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(g_q.irq) |-> $past(g_q.armed)); // R10

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(g_q.irq) |-> $past(pending)); // R9

endmodule

// File: rtl/usb_irq_aggregator.sv
module usb_irq_aggregator
    import usb_irq_agg_pkg::*;
#(
    parameter int unsigned       NUM_TX_EP = 16,
    parameter int unsigned       NUM_RX_EP = 15,
    parameter int unsigned       NUM_CORE  = 9,
    parameter logic [DATA_W-1:0] REV_VALUE = 32'h0001_0A03
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [NUM_TX_EP-1:0] tx_evt,
    input  logic [NUM_RX_EP-1:0] rx_evt,
    input  logic [NUM_CORE-1:0]  core_evt,
    output logic                 irq
);
    localparam int unsigned RX_LSB   = 17;   // EP1 receive lands above the unused bit 16
    localparam int unsigned CORE_LSB = 16;
    localparam logic [DATA_W-1:0] TX_FIELD   = DATA_W'((64'd1 << NUM_TX_EP) - 1);
    localparam logic [DATA_W-1:0] RX_FIELD   = DATA_W'(((64'd1 << NUM_RX_EP) - 1) << RX_LSB);
    localparam logic [DATA_W-1:0] EP_VALID   = TX_FIELD | RX_FIELD;
    localparam logic [DATA_W-1:0] CORE_VALID = DATA_W'(((64'd1 << NUM_CORE) - 1) << CORE_LSB);

    logic [DATA_W-1:0] ep_rise, core_rise;
    logic [DATA_W-1:0] ep_src, ep_msk, ep_mskd;
    logic [DATA_W-1:0] co_src, co_msk, co_mskd;
    bank_cmd_t         ep_cmd, co_cmd;
    logic              soft_rst, eoi_wr, pending, gate_armed;

    // write decode: one strobe vector per alias
    always_comb begin
        ep_cmd   = '0;
        co_cmd   = '0;
        soft_rst = 1'b0;
        eoi_wr   = 1'b0;
        if (reg_wr) begin
            unique case (reg_addr)
                OFS_EP_BASE + BK_SET:    ep_cmd.src_set = reg_wdata;
                OFS_EP_BASE + BK_CLR:    ep_cmd.src_clr = reg_wdata;
                OFS_EP_BASE + BK_MSET:   ep_cmd.msk_set = reg_wdata;
                OFS_EP_BASE + BK_MCLR:   ep_cmd.msk_clr = reg_wdata;
                OFS_CORE_BASE + BK_SET:  co_cmd.src_set = reg_wdata;
                OFS_CORE_BASE + BK_CLR:  co_cmd.src_clr = reg_wdata;
                OFS_CORE_BASE + BK_MSET: co_cmd.msk_set = reg_wdata;
                OFS_CORE_BASE + BK_MCLR: co_cmd.msk_clr = reg_wdata;
                OFS_CTRL:                soft_rst = reg_wdata[0];
                OFS_EOI:                 eoi_wr   = 1'b1;
                default: ;
            endcase
        end
    end

    irq_event_packer #(
        .NUM_TX   (NUM_TX_EP),
        .NUM_RX   (NUM_RX_EP),
        .NUM_CORE (NUM_CORE),
        .RX_LSB   (RX_LSB),
        .CORE_LSB (CORE_LSB)
    ) i_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_evt    (tx_evt),
        .rx_evt    (rx_evt),
        .core_evt  (core_evt),
        .ep_rise   (ep_rise),
        .core_rise (core_rise)
    );

    irq_src_bank #(.VALID(EP_VALID)) i_ep_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .hw_rise  (ep_rise),
        .cmd      (ep_cmd),
        .src      (ep_src),
        .msk      (ep_msk),
        .masked   (ep_mskd)
    );

    irq_src_bank #(.VALID(CORE_VALID)) i_core_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .hw_rise  (core_rise),
        .cmd      (co_cmd),
        .src      (co_src),
        .msk      (co_msk),
        .masked   (co_mskd)
    );

    assign pending = (|ep_mskd) | (|co_mskd);

    irq_eoi_gate i_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .eoi_wr   (eoi_wr),
        .pending  (pending),
        .irq      (irq),
        .armed    (gate_armed)
    );

    // read mux: aliases, control and EOI fall to the zero default
    always_comb begin
        unique case (reg_addr)
            OFS_REV:                 reg_rdata = REV_VALUE;
            OFS_STAT:                reg_rdata = {{(DATA_W-2){1'b0}}, gate_armed, irq};
            OFS_EP_BASE + BK_SRC:    reg_rdata = ep_src;
            OFS_EP_BASE + BK_MSK:    reg_rdata = ep_msk;
            OFS_EP_BASE + BK_MSKD:   reg_rdata = ep_mskd;
            OFS_CORE_BASE + BK_SRC:  reg_rdata = co_src;
            OFS_CORE_BASE + BK_MSK:  reg_rdata = co_msk;
            OFS_CORE_BASE + BK_MSKD: reg_rdata = co_mskd;
            default:                 reg_rdata = '0;
        endcase
    end

endmodule

// File: tb/test_usb_irq_aggregator.sv
module test_usb_irq_aggregator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] tx_evt = '0;
    logic [14:0] rx_evt = '0;
    logic [8:0]  core_evt = '0;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;   // 50 MHz

    usb_irq_aggregator i_usb_irq_aggregator (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tx_evt    (tx_evt),
        .rx_evt    (rx_evt),
        .core_evt  (core_evt),
        .irq       (irq)
    );

    // {is_read, requirement number, address, data (write value or expected read)}
    localparam int NV = 32;
    localparam logic [44:0] VEC [NV] = '{
        {1'b1, 4'd1,  8'h00, 32'h0001_0A03},   // R1 revision
        {1'b1, 4'd2,  8'h20, 32'h0000_0000},   // R2 empty after reset
        {1'b0, 4'd5,  8'h24, 32'hFFFF_FFFF},   // R5 force all
        {1'b1, 4'd2,  8'h20, 32'hFFFE_FFFF},   // R2 bit 16 stays 0
        {1'b1, 4'd8,  8'h38, 32'h0000_0000},   // R8 no mask
        {1'b0, 4'd6,  8'h28, 32'h0000_00FF},   // R6 clear low byte
        {1'b1, 4'd6,  8'h20, 32'hFFFE_FF00},   // R6
        {1'b0, 4'd7,  8'h30, 32'h0000_0F0F},   // R7 mask set
        {1'b1, 4'd7,  8'h2C, 32'h0000_0F0F},   // R7
        {1'b1, 4'd8,  8'h38, 32'h0000_0F00},   // R8 masked view
        {1'b1, 4'd13, 8'h08, 32'h0000_0001},   // R13 line up, gate taken
        {1'b0, 4'd7,  8'h34, 32'h0000_0F00},   // R7 mask clear
        {1'b1, 4'd7,  8'h2C, 32'h0000_000F},   // R7
        {1'b1, 4'd8,  8'h38, 32'h0000_0000},   // R8
        {1'b0, 4'd7,  8'h20, 32'h0000_0000},   // R7 direct source write
        {1'b1, 4'd7,  8'h20, 32'hFFFE_FF00},   // R7 ignored
        {1'b0, 4'd7,  8'h2C, 32'hFFFF_FFFF},   // R7 direct mask write
        {1'b1, 4'd7,  8'h2C, 32'h0000_000F},   // R7 ignored
        {1'b0, 4'd3,  8'h44, 32'hFFFF_FFFF},   // R3 force core
        {1'b1, 4'd3,  8'h40, 32'h01FF_0000},   // R3 nine bits only
        {1'b0, 4'd6,  8'h48, 32'h00FF_0000},   // R6 core clear
        {1'b1, 4'd6,  8'h40, 32'h0100_0000},   // R6
        {1'b1, 4'd1,  8'h24, 32'h0000_0000},   // R1 alias reads zero
        {1'b1, 4'd1,  8'h28, 32'h0000_0000},   // R1
        {1'b1, 4'd1,  8'h34, 32'h0000_0000},   // R1
        {1'b1, 4'd1,  8'h60, 32'h0000_0000},   // R1
        {1'b1, 4'd1,  8'h04, 32'h0000_0000},   // R1
        {1'b1, 4'd1,  8'h3C, 32'h0000_0000},   // R1 unmapped
        {1'b0, 4'd7,  8'h50, 32'h0100_0000},   // R7 core mask set
        {1'b1, 4'd8,  8'h58, 32'h0100_0000},   // R8 core masked
        {1'b1, 4'd7,  8'h4C, 32'h0100_0000},   // R7
        {1'b1, 4'd10, 8'h08, 32'h0000_0000}    // R10 gate still disarmed, line low
    };

    task automatic check(input string what, input int req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got %08h expected %08h", req, what, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #2;
        d = reg_rdata;
        @(negedge clk);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        tick(3);
        check("irq in reset", 9, {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        tick(1);
        bus_read(8'h08, rd);
        check("status after reset", 13, rd, 32'h0000_0002);   // R13

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][44]) begin
                bus_read(VEC[v][39:32], rd);
                check($sformatf("vector %0d read %02h", v, VEC[v][39:32]), int'(VEC[v][43:40]), rd, VEC[v][31:0]);
            end else begin
                bus_write(VEC[v][39:32], VEC[v][31:0]);
            end
        end

        // R12: control write with bit 0 clear has no effect
        bus_write(8'h04, 32'hFFFF_FFFE);
        bus_read(8'h40, rd);
        check("ctrl bit0 clear keeps core src", 12, rd, 32'h0100_0000);
        // R12: soft reset empties both banks and re-arms
        bus_write(8'h04, 32'h0000_0001);
        bus_read(8'h20, rd);  check("sreset ep src", 12, rd, 32'h0);
        bus_read(8'h4C, rd);  check("sreset core mask", 12, rd, 32'h0);
        bus_read(8'h08, rd);  check("sreset status", 12, rd, 32'h0000_0002);

        // R4 / R9: rising edge sets, line one clock later
        bus_write(8'h30, 32'hFFFF_FFFF);
        tx_evt[3] = 1'b1;
        tick(1);
        check("irq not yet", 9, {31'b0, irq}, 32'h0);
        tick(1);
        check("irq raised", 9, {31'b0, irq}, 32'h1);
        bus_read(8'h20, rd);  check("tx3 edge", 4, rd, 32'h0000_0008);

        // R4 / R10: clear while held high; no re-set, line falls, gate disarmed
        bus_write(8'h28, 32'h0000_0008);
        tick(2);
        bus_read(8'h20, rd);  check("held level no re-set", 4, rd, 32'h0);
        check("irq fell", 10, {31'b0, irq}, 32'h0);
        bus_read(8'h08, rd);  check("gate disarmed", 10, rd, 32'h0);

        // R2 / R10: EP1 receive lands at bit 17, no line while disarmed
        rx_evt[0] = 1'b1;
        tick(1);
        rx_evt[0] = 1'b0;
        tick(3);
        bus_read(8'h20, rd);  check("rx ep1 bit", 2, rd, 32'h0002_0000);
        check("no irq while disarmed", 10, {31'b0, irq}, 32'h0);

        // R11: EOI re-arms; pending work re-asserts
        bus_write(8'h60, 32'h1234_5678);
        check("irq low at eoi", 11, {31'b0, irq}, 32'h0);
        tick(1);
        check("irq after eoi", 11, {31'b0, irq}, 32'h1);
        bus_write(8'h60, 32'h0);
        check("irq drop on second eoi", 11, {31'b0, irq}, 32'h0);
        tick(1);
        check("irq back", 11, {31'b0, irq}, 32'h1);

        // R6: hardware edge and software clear on the same bit, same cycle
        tx_evt[5] = 1'b1;
        bus_write(8'h28, 32'h0000_0020);
        bus_read(8'h20, rd);  check("rise beats clear", 6, rd, 32'h0002_0020);

        // R3: VBUS-drive event to bit 24
        core_evt[8] = 1'b1;
        tick(1);
        bus_read(8'h40, rd);  check("vbus drive bit", 3, rd, 32'h0100_0000);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule